// File: doc/BRIEF.md
# Banked Cartridge Memory Mapper with Clock-Register Window

This block sits between a console's 16-bit address / 8-bit data bus and the memories on a cartridge. Writes into the lower half of the address space do not reach ROM. They are decoded as control writes. The mapper uses them to choose which ROM bank appears in the upper ROM half, and which 8 KiB external RAM bank appears in the 0xA000–0xBFFF window. The same writes gate access to that window and send commands to a small set of clock registers.

The mapper never holds ROM data or RAM data. It forms a ROM byte address for an external ROM. It forms a bank-extended address and a write strobe for an external RAM. It returns the byte that belongs on the bus for window reads. One selector register does two jobs. Small values pick a RAM bank. A second range of values, accepted only when the timer parameter is set, redirects the window to one of five stored clock registers. Reads of these registers return a latched copy, which a two-step latch command refreshes from the live registers.

Top module: `cart_mapper`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0, no clock register is selected and window access is off.
- R2: A write to 0x0000–0x1FFF turns window access on when the data is 0x0A, and turns it off for any other data value.
- R3: A write to 0x2000–0x3FFF loads the ROM bank. A value above ROM_BANKS-1 is stored as ROM_BANKS-1, and 0 is stored as 1.
- R4: rom_cs is high for addresses below 0x8000. For 0x0000–0x3FFF, rom_addr equals address bits 13:0 (bank 0). For 0x4000–0x7FFF, rom_addr is bank × 0x4000 + address bits 13:0.
- R5: A write to 0x4000–0x5FFF with data 0x00–0x03 selects that RAM bank and leaves clock mode. ext_ram_addr is {bank[1:0], address bits 12:0}, which equals (address − 0xA000) + 0x2000 × bank inside the window.
- R6: A read in 0xA000–0xBFFF returns 0xFF when access is off, or when no RAM is fitted and no clock register is selected. A read outside the window also returns 0xFF.
- R7: ext_ram_we is high only for a window write while access is on, RAM is fitted and no clock register is selected. ext_ram_wdata carries the bus data.
- R8: A selector write with data 0x08–0x0C selects clock register (data − 0x08), but only when HAS_TIMER is 1. Selector data 0x04–0x07 or 0x0D–0xFF, and clock values on a part without a timer, leave the selection unchanged.
- R9: While a clock register is selected and access is on, a window write updates that live register and not RAM, and a window read returns its latched copy.
- R10: A write to 0x6000–0x7FFF with data 0x01 copies all live clock registers into the latched copies only when the previous write to that range carried 0x00. Any other sequence leaves the latched copies unchanged.
- R11: A control write does not change the ROM address, RAM address or read data presented in its own cycle. Its effect appears from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | CPU bus address |
| bus_wdata | input | 8 | CPU bus write data |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Read data for the external window (0xFF when not driven) |
| rom_cs | output | 1 | Address lies in ROM space |
| rom_addr | output | $clog2(ROM_BANKS)+14 | ROM byte address |
| ext_ram_addr | output | 15 | External RAM byte address |
| ext_ram_wdata | output | 8 | External RAM write data |
| ext_ram_we | output | 1 | External RAM write strobe |
| ext_ram_rdata | input | 8 | External RAM read data |

## Verification
A control write and the read-side address mapping happen in the same bus cycle. For example, a selector write at 0x4ABC is itself an access to the switchable ROM half. The bench samples rom_addr, ext_ram_we and the strobes in the middle of each write cycle. It requires the ROM address to be built from the bank that was current before the write. The write's effect is judged on the reads in the following cycles. The sweeps over all 256 data values for the enable, ROM-bank and selector writes do this at varied addresses within each range.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    typedef enum logic [2:0] {
        WR_ENABLE,
        WR_ROMBANK,
        WR_SELECT,
        WR_LATCH,
        WR_WINDOW,
        WR_NONE
    } wr_target_e;

    typedef enum logic [1:0] {
        SEL_RAM,
        SEL_CLOCK,
        SEL_IGNORE
    } sel_kind_e;

    typedef struct packed {
        logic       access_on;
        logic [7:0] rom_bank;
        logic [1:0] ram_bank;
        logic       clock_mode;
        logic [2:0] clock_idx;
    } ctrl_t;

    localparam logic [7:0] ENABLE_KEY  = 8'h0A;
    localparam logic [7:0] RAM_SEL_MAX = 8'h03;
    localparam logic [7:0] CLOCK_FIRST = 8'h08;
    localparam logic [7:0] CLOCK_LAST  = 8'h0C;
    localparam logic [7:0] LATCH_ARM   = 8'h00;
    localparam logic [7:0] LATCH_FIRE  = 8'h01;
    localparam logic [7:0] OPEN_BUS    = 8'hFF;

    function automatic wr_target_e decode_target(input logic [2:0] hi);
        case (hi)
            3'b000:  return WR_ENABLE;
            3'b001:  return WR_ROMBANK;
            3'b010:  return WR_SELECT;
            3'b011:  return WR_LATCH;
            3'b101:  return WR_WINDOW;
            default: return WR_NONE;
        endcase
    endfunction

    function automatic sel_kind_e classify_sel(input logic [7:0] d, input logic timer_present);
        if (d <= RAM_SEL_MAX)
            return SEL_RAM;
        if (timer_present && d >= CLOCK_FIRST && d <= CLOCK_LAST)
            return SEL_CLOCK;
        return SEL_IGNORE;
    endfunction

    function automatic logic [7:0] clamp_rom_bank(input logic [7:0] d, input logic [7:0] highest);
        logic [7:0] b;
        b = d;
        if (b > highest)
            b = highest;
        if (b == 8'd0)
            b = 8'd1;
        return b;
    endfunction

endpackage

// File: rtl/mapper_ctrl_regs.sv
module mapper_ctrl_regs
    import mapper_pkg::*;
#(
    parameter int ROM_BANKS = 64,
    parameter bit HAS_TIMER = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] addr_hi,
    input  logic [7:0] wdata,
    output ctrl_t      ctrl
);
    localparam logic [7:0] HIGHEST = 8'(ROM_BANKS - 1);

    wr_target_e tgt;
    sel_kind_e  kind;
    ctrl_t      nxt;

    always_comb begin
        tgt  = decode_target(addr_hi);
        kind = classify_sel(wdata, HAS_TIMER);
        nxt  = ctrl;
        if (wr_en) begin
            case (tgt)
                WR_ENABLE:  nxt.access_on = (wdata == ENABLE_KEY);
                WR_ROMBANK: nxt.rom_bank  = clamp_rom_bank(wdata, HIGHEST);
                WR_SELECT: begin
                    case (kind)
                        SEL_RAM: begin
                            nxt.ram_bank   = wdata[1:0];
                            nxt.clock_mode = 1'b0;
                        end
                        SEL_CLOCK: begin
                            nxt.clock_mode = 1'b1;
                            nxt.clock_idx  = 3'(wdata - CLOCK_FIRST);
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.access_on  <= 1'b0;
            ctrl.rom_bank   <= 8'd1;
            ctrl.ram_bank   <= 2'd0;
            ctrl.clock_mode <= 1'b0;
            ctrl.clock_idx  <= 3'd0;
        end else begin
            ctrl <= nxt;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl.rom_bank == 8'd1 && !ctrl.access_on &&
                        ctrl.ram_bank == 2'd0 && !ctrl.clock_mode));

    assert_enable_key_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr_hi == 3'b000) |=> (ctrl.access_on == ($past(wdata) == 8'h0A)));

    assert_bank_range_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.rom_bank != 8'd0 && ctrl.rom_bank <= HIGHEST));

    assert_sel_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr_hi == 3'b010 && wdata >= 8'h04 && wdata <= 8'h07)
        |=> ($stable(ctrl.clock_mode) && $stable(ctrl.ram_bank) && $stable(ctrl.clock_idx)));

endmodule

// File: rtl/mapper_clock_regs.sv
module mapper_clock_regs
    import mapper_pkg::*;
#(
    parameter int CLK_REGS = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       live_we,
    input  logic [2:0] idx,
    input  logic [7:0] wdata,
    input  logic       latch_we,
    input  logic [7:0] latch_data,
    output logic [7:0] latched_rdata
);
    localparam int FLAT_W = CLK_REGS * 8;

    logic [FLAT_W-1:0] live_flat;
    logic [FLAT_W-1:0] held_flat;
    logic [7:0]        last_cmd;
    logic              capture;

    assign capture = latch_we && (latch_data == LATCH_FIRE) && (last_cmd == LATCH_ARM);

    always_ff @(posedge clk) begin
        if (rst)
            last_cmd <= OPEN_BUS;
        else if (latch_we)
            last_cmd <= latch_data;
    end

    for (genvar g = 0; g < CLK_REGS; g++) begin : g_reg
        logic [7:0] live_q;
        logic [7:0] held_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                live_q <= 8'd0;
                held_q <= 8'd0;
            end else begin
                if (live_we && idx == 3'(g))
                    live_q <= wdata;
                if (capture)
                    held_q <= live_q;
            end
        end

        assign live_flat[g*8 +: 8] = live_q;
        assign held_flat[g*8 +: 8] = held_q;
    end

    always_comb begin
        latched_rdata = OPEN_BUS;
        for (int k = 0; k < CLK_REGS; k++) begin
            if (idx == 3'(k))
                latched_rdata = held_flat[k*8 +: 8];
        end
    end

    assert_latch_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(latch_we && latch_data == 8'h01) |=> $stable(held_flat));

    assert_latch_copy_R10: assert property (@(posedge clk) disable iff (rst)
        capture |=> (held_flat == $past(live_flat)));

endmodule

// File: rtl/mapper_addr_path.sv
module mapper_addr_path
    import mapper_pkg::*;
#(
    parameter int ROM_BANKS = 64,
    parameter bit HAS_RAM   = 1'b1,
    localparam int ROM_AW   = $clog2(ROM_BANKS) + 14
) (
    input  logic [15:0]       addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    input  ctrl_t             ctrl,
    input  logic [7:0]        clock_rdata,
    input  logic [7:0]        ext_ram_rdata,
    output logic              rom_cs,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [14:0]       ext_ram_addr,
    output logic [7:0]        ext_ram_wdata,
    output logic              ext_ram_we,
    output logic              clock_we,
    output logic [7:0]        bus_rdata
);
    logic win;
    logic ram_path;
    logic clock_path;

    always_comb begin
        win        = (decode_target(addr[15:13]) == WR_WINDOW);
        ram_path   = ctrl.access_on && !ctrl.clock_mode && (HAS_RAM != 1'b0);
        clock_path = ctrl.access_on && ctrl.clock_mode;

        rom_cs   = !addr[15];
        rom_addr = ROM_AW'({(addr[14] ? ctrl.rom_bank : 8'd0), addr[13:0]});

        ext_ram_addr  = {ctrl.ram_bank, addr[12:0]};
        ext_ram_wdata = wdata;
        ext_ram_we    = wr_en && win && ram_path;
        clock_we      = wr_en && win && clock_path;

        if (!win)
            bus_rdata = OPEN_BUS;
        else if (clock_path)
            bus_rdata = clock_rdata;
        else if (ram_path)
            bus_rdata = ext_ram_rdata;
        else
            bus_rdata = OPEN_BUS;
    end

endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
    import mapper_pkg::*;
#(
    parameter int ROM_BANKS = 64,
    parameter bit HAS_RAM   = 1'b1,
    parameter bit HAS_TIMER = 1'b1,
    parameter int CLK_REGS  = 5,
    localparam int ROM_AW   = $clog2(ROM_BANKS) + 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    output logic [7:0]        bus_rdata,
    output logic              rom_cs,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [14:0]       ext_ram_addr,
    output logic [7:0]        ext_ram_wdata,
    output logic              ext_ram_we,
    input  logic [7:0]        ext_ram_rdata
);
    ctrl_t      ctrl;
    logic [7:0] clock_rdata;
    logic       clock_we;
    logic       latch_we;

    assign latch_we = bus_wr && (decode_target(bus_addr[15:13]) == WR_LATCH);

    mapper_ctrl_regs #(
        .ROM_BANKS (ROM_BANKS),
        .HAS_TIMER (HAS_TIMER)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr),
        .addr_hi (bus_addr[15:13]),
        .wdata   (bus_wdata),
        .ctrl    (ctrl)
    );

    if (HAS_TIMER) begin : g_timer
        mapper_clock_regs #(
            .CLK_REGS (CLK_REGS)
        ) u_clock (
            .clk           (clk),
            .rst           (rst),
            .live_we       (clock_we),
            .idx           (ctrl.clock_idx),
            .wdata         (bus_wdata),
            .latch_we      (latch_we),
            .latch_data    (bus_wdata),
            .latched_rdata (clock_rdata)
        );
    end else begin : g_no_timer
        assign clock_rdata = OPEN_BUS;
    end

    mapper_addr_path #(
        .ROM_BANKS (ROM_BANKS),
        .HAS_RAM   (HAS_RAM)
    ) u_path (
        .addr          (bus_addr),
        .wr_en         (bus_wr),
        .wdata         (bus_wdata),
        .ctrl          (ctrl),
        .clock_rdata   (clock_rdata),
        .ext_ram_rdata (ext_ram_rdata),
        .rom_cs        (rom_cs),
        .rom_addr      (rom_addr),
        .ext_ram_addr  (ext_ram_addr),
        .ext_ram_wdata (ext_ram_wdata),
        .ext_ram_we    (ext_ram_we),
        .clock_we      (clock_we),
        .bus_rdata     (bus_rdata)
    );

    assert_rom_fixed_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[15:14] == 2'b00) |-> (rom_cs && rom_addr == ROM_AW'(bus_addr[13:0])));

    assert_window_closed_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[15:13] == 3'b101 && !ctrl.access_on) |-> (bus_rdata == 8'hFF));

    assert_ram_we_guard_R7: assert property (@(posedge clk) disable iff (rst)
        ext_ram_we |-> (ctrl.access_on && !ctrl.clock_mode && bus_addr[15:13] == 3'b101));

    assert_clock_no_ram_R9: assert property (@(posedge clk) disable iff (rst)
        ctrl.clock_mode |-> !ext_ram_we);

    assert_window_offset_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[15:13] == 3'b101) |-> (ext_ram_addr[12:0] == bus_addr[12:0]));

endmodule

// File: tb/sim_cart_mapper.sv
module sim_cart_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int NBANK      = 16;
    localparam int AW         = $clog2(NBANK) + 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_wr = 1'b0;

    logic [7:0]    rdata0, rdata1, wd0, wd1, ram_rd0, ram_rd1;
    logic          cs0, cs1, we0, we1;
    logic [AW-1:0] ra0, ra1;
    logic [14:0]   ea0, ea1;

    int n_cmp = 0;
    int n_bad = 0;

    logic          p_we0, p_we1;
    logic [AW-1:0] p_ra0;
    logic [7:0]    p_wd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_of(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]};
    endfunction

    function automatic int exp_bank(input int v);
        int b;
        b = (v > NBANK - 1) ? NBANK - 1 : v;
        if (b == 0) b = 1;
        return b;
    endfunction

    assign ram_rd0 = mem_of(ea0);
    assign ram_rd1 = mem_of(ea1);

    cart_mapper #(.ROM_BANKS(NBANK), .HAS_RAM(1'b1), .HAS_TIMER(1'b1)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rdata(rdata0), .rom_cs(cs0), .rom_addr(ra0), .ext_ram_addr(ea0),
        .ext_ram_wdata(wd0), .ext_ram_we(we0), .ext_ram_rdata(ram_rd0));

    cart_mapper #(.ROM_BANKS(NBANK), .HAS_RAM(1'b0), .HAS_TIMER(1'b0)) u1 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rdata(rdata1), .rom_cs(cs1), .rom_addr(ra1), .ext_ram_addr(ea1),
        .ext_ram_wdata(wd1), .ext_ram_we(we1), .ext_ram_rdata(ram_rd1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        #1;
        p_we0 = we0;
        p_we1 = we1;
        p_ra0 = ra0;
        p_wd0 = wd0;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a);
        @(negedge clk);
        bus_addr = a;
        bus_wr   = 1'b0;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(16'h4000);
        chk("R1 rom bank 1", 32'(ra0), 32'(16384));
        rd(16'hA000);
        chk("R1 access off", 32'(rdata0), 32'hFF);
        chk("R1 no ram write", 32'(we0), 32'h0);

        // R2: enable sweep over all data values
        for (int v = 0; v < 256; v++) begin
            wr({3'b000, 13'(v * 31)}, 8'(v));
            rd(16'hA010);
            chk("R2 enable", 32'(rdata0),
                32'((v == 10) ? mem_of(15'h0010) : 8'hFF));
        end
        wr(16'h1FFF, 8'h0A);
        rd(16'hA005);
        chk("R1 ram bank 0", 32'(ea0), 32'h0005);

        // R3 and R4: ROM bank sweep
        for (int v = 0; v < 256; v++) begin
            logic [13:0] off;
            off = 14'(v * 37);
            wr({3'b001, 13'(v * 17)}, 8'(v));
            rd({2'b01, off});
            chk("R3 bank clamp", 32'(ra0), 32'(exp_bank(v) * 16384 + int'(off)));
            chk("R4 rom cs", 32'(cs0), 32'h1);
            rd({2'b00, off});
            chk("R4 fixed bank", 32'(ra0), 32'(off));
        end
        rd(16'h8000);
        chk("R4 above rom", 32'(cs0), 32'h0);

        // R11: control write leaves same-cycle mapping untouched
        wr(16'h2000, 8'h05);
        wr(16'h4ABC, 8'h02);
        chk("R11 rom addr during write", 32'(p_ra0), 32'(5 * 16384 + 16'h0ABC));
        wr(16'h2000, 8'h09);
        chk("R11 old bank during bank write", 32'(p_ra0), 32'h2000);
        rd(16'h4001);
        chk("R11 new bank next cycle", 32'(ra0), 32'(9 * 16384 + 1));

        // clock registers: set live values, then latch
        for (int i = 0; i < 5; i++) begin
            wr(16'h4000, 8'(8 + i));
            wr(16'hA000, 8'(8'h50 + i));
        end
        wr(16'h6000, 8'h00);
        wr(16'h6000, 8'h01);

        // R5 and R8: selector sweep
        for (int v = 0; v < 256; v++) begin
            logic [12:0] off;
            off = 13'(v * 13);
            wr(16'h4000, 8'h02);
            wr({3'b010, 13'(v * 29)}, 8'(v));
            rd({3'b101, off});
            if (v <= 3) begin
                chk("R5 ram bank addr", 32'(ea0), 32'({2'(v), off}));
                chk("R5 ram bank data", 32'(rdata0), 32'(mem_of({2'(v), off})));
            end else if (v >= 8 && v <= 12) begin
                chk("R8 clock select", 32'(rdata0), 32'(8'h50 + v - 8));
            end else begin
                chk("R8 ignored value", 32'(rdata0), 32'(mem_of({2'd2, off})));
            end
        end

        // R7: RAM write strobe
        wr(16'h4000, 8'h01);
        wr(16'hA0F0, 8'h77);
        chk("R7 ram we on", 32'(p_we0), 32'h1);
        chk("R7 ram wdata", 32'(p_wd0), 32'h77);
        wr(16'h0000, 8'h00);
        wr(16'hA0F0, 8'h78);
        chk("R7 ram we off when disabled", 32'(p_we0), 32'h0);
        wr(16'h0000, 8'h0A);
        wr(16'h3000, 8'h01);
        chk("R7 no we outside window", 32'(p_we0), 32'h0);

        // R9 and R10: clock register path and latch sequencing
        wr(16'h4000, 8'h09);
        wr(16'hA123, 8'h99);
        chk("R9 no ram we in clock mode", 32'(p_we0), 32'h0);
        rd(16'hA000);
        chk("R9 reads latched copy", 32'(rdata0), 32'h51);
        wr(16'h6000, 8'h00);
        wr(16'h7FFF, 8'h01);
        rd(16'hB000);
        chk("R10 latch copies live", 32'(rdata0), 32'h99);
        wr(16'hA000, 8'hAA);
        wr(16'h6000, 8'h01);
        rd(16'hA000);
        chk("R10 fire without arm", 32'(rdata0), 32'h99);
        wr(16'h6000, 8'h00);
        wr(16'h6000, 8'h05);
        wr(16'h6000, 8'h01);
        rd(16'hA000);
        chk("R10 broken sequence", 32'(rdata0), 32'h99);
        wr(16'h6000, 8'h00);
        wr(16'h6000, 8'h01);
        rd(16'hA000);
        chk("R10 second latch", 32'(rdata0), 32'hAA);
        wr(16'h0000, 8'h00);
        rd(16'hA000);
        chk("R6 clock mode disabled", 32'(rdata0), 32'hFF);
        wr(16'h0000, 8'h0A);
        rd(16'h9000);
        chk("R6 outside window", 32'(rdata0), 32'hFF);

        // R6 and R8 on the instance without RAM or timer
        rd(16'hA040);
        chk("R6 no ram fitted", 32'(rdata1), 32'hFF);
        wr(16'hA040, 8'h12);
        chk("R6 no ram write strobe", 32'(p_we1), 32'h0);
        wr(16'h4000, 8'h03);
        wr(16'h4000, 8'h08);
        rd(16'hA001);
        chk("R8 no timer keeps bank", 32'(ea1), 32'({2'd3, 13'h0001}));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule